// File: doc/BRIEF.md
# Asynchronous Serial Port with Nine-Bit Address Filtering

This block is a full-duplex asynchronous serial port. Software programs it through two 8-bit registers: a control register and a data register. Writing the data register while the transmitter is idle sends one frame. A frame that passes the receive filter is placed in the data register, where software can read it.

Each frame carries eight data bits. A control bit can add a ninth bit. In nine-bit mode the transmitted ninth bit comes from a writable control field, and the received ninth bit is captured into another control field. When address filtering is on in nine-bit mode, frames whose ninth bit is 0 are dropped without notice. This lets a node on a shared line ignore traffic not addressed to it.

Two sticky flags signal completion, one for transmit and one for receive. Each drives an interrupt request output. The bit rate is set outside the block by a tick input that pulses at sixteen times the bit rate.

Top module: `uart9_port`

## Requirements
- R1: The frame is sent least significant bit first. It has one start bit (0), eight data bits, a ninth bit when ctl[7]=1, and one stop bit (1). Every bit lasts 16 baud ticks. The line idles high, including after reset.
- R2: The control register is at address 0: [7] nine-bit mode, [6] reserved (reads 0), [5] address filter, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit-done flag, [0] receive-done flag. The data register is at address 1. Every field resets to 0.
- R3: A write to address 1 while the transmitter is idle drives the start bit on tx_o from the next cycle. A write to address 1 while a frame is in progress is ignored.
- R4: In nine-bit mode, the ninth transmitted bit is the value that ctl[3] held when the frame was started.
- R5: ctl[1] is set in the cycle the stop bit ends, and ctl[0] is set when a frame is accepted. Both stay set until software writes 0 to them. If a hardware set and a software write fall in the same cycle, the flag ends up 1.
- R6: Reception starts only while ctl[4]=1. A start bit whose majority vote over the middle samples (ticks 7 to 9) is not low is rejected, and the receiver returns to idle.
- R7: In nine-bit mode with the filter off, an accepted frame stores its byte at address 1 and its ninth bit in ctl[2], and sets ctl[0].
- R8: In eight-bit mode with the filter off, the received stop bit is stored in ctl[2].
- R9: In nine-bit mode with the filter on, a frame whose ninth bit is 0 is dropped: ctl[0], ctl[2] and the data register keep their values. A frame whose ninth bit is 1 is accepted.
- R10: In eight-bit mode with the filter on, a frame with a low stop bit is dropped. An accepted frame leaves ctl[2] unchanged.
- R11: A frame that completes while ctl[0] is still 1 is dropped, and the data register keeps its earlier byte.
- R12: reg_rdata is registered. It shows the register chosen by reg_addr one cycle after reg_addr is presented.
- R13: irq_tx follows ctl[1] and irq_rx follows ctl[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-done request |
| irq_rx | output | 1 | Receive-done request |

## Verification
Two events can land on the same clock edge: the transmitter setting its done flag as the stop bit ends, and a software write to the control register that clears that flag. The bench times a control write to the exact baud tick that ends the stop bit, using its own line model. It then checks that the flag reads 1. A later ordinary write must still clear the flag. The transmit line and the flag are compared against that model on every clock. The receive filters, the overrun rule and start-bit rejection are each checked by reading both registers back after a frame.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int DATA_W = 8;
  // control register bit positions
  localparam int B_MODE9 = 7;
  localparam int B_RSVD  = 6;
  localparam int B_MPE   = 5;
  localparam int B_REN   = 4;
  localparam int B_TB8   = 3;
  localparam int B_RB8   = 2;
  localparam int B_TI    = 1;
  localparam int B_RI    = 0;
  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_DAT = 1'b1;

  typedef struct packed {
    logic mode9;
    logic mpe;
    logic ren;
    logic tb8;
    logic rb8;
    logic ti;
    logic ri;
  } ctl_t;
endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  always_ff @(posedge clk) begin
    if (rst) r <= '1;
    else     r <= {r[STAGES-2:0], d};
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] din,
  input  logic          mode9,
  input  logic          ninth,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int PW = $clog2(OVS);
  localparam int LW = $clog2(DW + 3);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [LW-1:0] N_BITS9 = LW'(DW + 2);
  localparam logic [LW-1:0] N_BITS8 = LW'(DW + 1);

  logic [DW+1:0] sh;
  logic [LW-1:0] left;
  logic [PW-1:0] ph;
  logic          bit_end;

  assign bit_end = busy && tick && (ph == PH_LAST);
  assign done    = bit_end && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      left <= '0;
      ph   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        txd  <= 1'b0;
        ph   <= '0;
        sh   <= {1'b1, (mode9 ? ninth : 1'b1), din};
        left <= mode9 ? N_BITS9 : N_BITS8;
      end
    end else if (tick) begin
      if (ph == PH_LAST) begin
        ph <= '0;
        if (left == '0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[DW+1:1]};
          left <= left - 1'b1;
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          en,
  input  logic          mode9,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stopb
);
  localparam int PW = $clog2(OVS);
  localparam int IW = $clog2(DW + 3);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_S0   = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] PH_S1   = PW'(OVS / 2);
  localparam logic [PW-1:0] PH_S2   = PW'(OVS / 2 + 1);
  localparam logic [IW-1:0] IX_DLAST = IW'(DW);
  localparam logic [IW-1:0] IX_STOP8 = IW'(DW + 1);
  localparam logic [IW-1:0] IX_STOP9 = IW'(DW + 2);

  logic          busy;
  logic          m9;
  logic [PW-1:0] ph;
  logic [IW-1:0] ix;
  logic [1:0]    smp;
  logic [DW-1:0] sh;
  logic          vote, sampling, decide, last_bit;

  assign sampling = busy && tick && (ph == PH_S0 || ph == PH_S1);
  assign decide   = busy && tick && (ph == PH_S2);
  assign vote     = (smp[1] & smp[0]) | (smp[1] & rxd) | (smp[0] & rxd);
  assign last_bit = m9 ? (ix == IX_STOP9) : (ix == IX_STOP8);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      m9    <= 1'b0;
      ph    <= '0;
      ix    <= '0;
      smp   <= '0;
      sh    <= '0;
      valid <= 1'b0;
      data  <= '0;
      bit9  <= 1'b0;
      stopb <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!busy) begin
        if (tick && en && !rxd) begin
          busy <= 1'b1;
          m9   <= mode9;
          ph   <= PW'(1);
          ix   <= '0;
        end
      end else if (tick) begin
        if (sampling) smp <= {smp[0], rxd};
        if (decide) begin
          if (last_bit) begin
            busy  <= 1'b0;
            valid <= 1'b1;
            stopb <= vote;
            data  <= sh;
          end else if (ix == '0) begin
            if (vote) busy <= 1'b0;
          end else if (ix <= IX_DLAST) begin
            sh <= {vote, sh[DW-1:1]};
          end else begin
            bit9 <= vote;
          end
        end
        if (ph == PH_LAST) begin
          ph <= '0;
          ix <= ix + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart9_port.sv
module uart9_port
  import uart9_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              baud_tick,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              irq_tx,
  output logic              irq_rx
);
  ctl_t              ctl;
  logic [DATA_W-1:0] rxbuf;
  logic [DATA_W-1:0] ctl_byte;
  logic              wr_ctl, wr_dat;
  logic              rx_s;
  logic              tx_busy, tx_done;
  logic              rx_valid, rx_b9, rx_stop;
  logic [DATA_W-1:0] rx_data;
  logic              rx_take, rb8_load, rb8_val;
  logic              ctl_ren;

  assign wr_ctl  = reg_wr && (reg_addr == ADDR_CTL);
  assign wr_dat  = reg_wr && (reg_addr == ADDR_DAT);
  assign ctl_ren = ctl.ren;

  uart9_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx_i), .q(rx_s)
  );

  uart9_tx #(.DW(DATA_W), .OVS(OVERSAMPLE)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .start(wr_dat),
    .din(reg_wdata), .mode9(ctl.mode9), .ninth(ctl.tb8),
    .txd(tx_o), .busy(tx_busy), .done(tx_done)
  );

  uart9_rx #(.DW(DATA_W), .OVS(OVERSAMPLE)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rx_s), .en(ctl.ren),
    .mode9(ctl.mode9), .valid(rx_valid), .data(rx_data),
    .bit9(rx_b9), .stopb(rx_stop)
  );

  // acceptance filter: enable, no pending frame, address/stop qualification
  assign rx_take  = rx_valid && ctl.ren && !ctl.ri &&
                    (ctl.mode9 ? (!ctl.mpe || rx_b9) : (!ctl.mpe || rx_stop));
  assign rb8_load = rx_take && (ctl.mode9 || !ctl.mpe);
  assign rb8_val  = ctl.mode9 ? rx_b9 : rx_stop;

  always_comb begin
    ctl_byte          = '0;
    ctl_byte[B_MODE9] = ctl.mode9;
    ctl_byte[B_RSVD]  = 1'b0;
    ctl_byte[B_MPE]   = ctl.mpe;
    ctl_byte[B_REN]   = ctl.ren;
    ctl_byte[B_TB8]   = ctl.tb8;
    ctl_byte[B_RB8]   = ctl.rb8;
    ctl_byte[B_TI]    = ctl.ti;
    ctl_byte[B_RI]    = ctl.ri;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      rxbuf     <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_ctl) begin
        ctl.mode9 <= reg_wdata[B_MODE9];
        ctl.mpe   <= reg_wdata[B_MPE];
        ctl.ren   <= reg_wdata[B_REN];
        ctl.tb8   <= reg_wdata[B_TB8];
        ctl.rb8   <= reg_wdata[B_RB8];
        ctl.ti    <= reg_wdata[B_TI];
        ctl.ri    <= reg_wdata[B_RI];
      end
      // hardware sets win over a same-cycle software write
      if (tx_done) ctl.ti <= 1'b1;
      if (rx_take) begin
        ctl.ri <= 1'b1;
        rxbuf  <= rx_data;
      end
      if (rb8_load) ctl.rb8 <= rb8_val;
      reg_rdata <= (reg_addr == ADDR_DAT) ? rxbuf : ctl_byte;
    end
  end

  assign irq_tx = ctl.ti;
  assign irq_rx = ctl.ri;
endmodule

// File: rtl/uart9_port_chk.sv
module uart9_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic       baud_tick,
  input logic       tx_o,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic       ren
);
  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> tx_o);

  a_r3_line_moves_on_tick_or_start: assert property (@(posedge clk) disable iff (rst)
    (!baud_tick && !(reg_wr && reg_addr)) |=> $stable(tx_o));

  a_r5_ti_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_tx && !(reg_wr && !reg_addr)) |=> irq_tx);

  a_r5_ri_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_rx && !(reg_wr && !reg_addr)) |=> irq_rx);

  a_r6_no_rx_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (!irq_rx && !ren && !(reg_wr && !reg_addr)) |=> !irq_rx);

  a_r1_done_with_line_high: assert property (@(posedge clk) disable iff (rst)
    (!irq_tx && !(reg_wr && !reg_addr && reg_wdata[1])) |=> (!irq_tx || tx_o));
endmodule

bind uart9_port uart9_port_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .baud_tick(baud_tick), .tx_o(tx_o),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .ren(ctl_ren)
);

// File: tb/test_uart9_port.sv
module test_uart9_port;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 64;   // 16 ticks, one tick every 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       baud_tick = 1'b0;
  logic       rx_i = 1'b1;
  logic       tx_o, irq_tx, irq_rx;

  int n_chk = 0;
  int n_fail = 0;
  int tcnt = 0;

  uart9_port i_uart9_port (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
    .rx_i(rx_i), .tx_o(tx_o), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      tcnt = 0;
      baud_tick = 1'b0;
    end else begin
      baud_tick = (tcnt == 3);
      tcnt = (tcnt + 1) % 4;
    end
  end

  // behavioural model of transmit line and transmit-done flag
  logic m_tx = 1'b1, m_ti = 1'b0, m_busy = 1'b0, m_mode9 = 1'b0, m_tb8 = 1'b0;
  logic ti_n;
  int   m_cnt = 0;
  bit   q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_tx = 1'b1; m_ti = 1'b0; m_busy = 1'b0; m_mode9 = 1'b0; m_tb8 = 1'b0;
      q.delete();
    end else begin
      ti_n = m_ti;
      if (reg_wr && !reg_addr) ti_n = reg_wdata[1];
      if (m_busy) begin
        if (baud_tick) begin
          m_cnt--;
          if (m_cnt == 0) begin
            if (q.size() == 0) begin
              m_busy = 1'b0; m_tx = 1'b1; ti_n = 1'b1;
            end else begin
              m_tx = q.pop_front(); m_cnt = 16;
            end
          end
        end
      end else if (reg_wr && reg_addr) begin
        q.delete();
        for (int i = 0; i < 8; i++) q.push_back(reg_wdata[i]);
        if (m_mode9) q.push_back(m_tb8);
        q.push_back(1'b1);
        m_tx = 1'b0; m_cnt = 16; m_busy = 1'b1;
      end
      if (reg_wr && !reg_addr) begin
        m_mode9 = reg_wdata[7];
        m_tb8   = reg_wdata[3];
      end
      m_ti = ti_n;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check({7'd0, tx_o}, {7'd0, m_tx}, "R1/R3/R4 tx line");
      check({7'd0, irq_tx}, {7'd0, m_ti}, "R5/R13 transmit flag");
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic line(input logic v);
    rx_i = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic has9, input logic b9, input logic stopv);
    line(1'b0);
    for (int i = 0; i < 8; i++) line(d[i]);
    if (has9) line(b9);
    if (stopv) line(1'b1);
    else begin
      rx_i = 1'b0;
      repeat (48) @(negedge clk);
      rx_i = 1'b1;
      repeat (80) @(negedge clk);
    end
    line(1'b1);
  endtask

  task automatic wait_tx();
    while (m_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_regs(input logic [7:0] ectl, input logic [7:0] edat, input string req);
    logic [7:0] v;
    rd(1'b0, v); check(v, ectl, req);
    rd(1'b1, v); check(v, edat, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state, R2 R12
    expect_regs(8'h00, 8'h00, "R2 reset");
    check({7'd0, irq_rx}, 8'h00, "R13 reset irq_rx");
    // all-ones write, reserved reads 0 (R2, R12)
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check(v, 8'hBF, "R2 control layout");
    check({6'd0, irq_tx, irq_rx}, 8'h03, "R13 flags drive requests");
    wr(1'b0, 8'h00);
    rd(1'b0, v); check(v, 8'h00, "R5 software clear");

    // eight-bit transmit, R1 R3
    wr(1'b1, 8'hA5);
    repeat (100) @(negedge clk);
    wr(1'b1, 8'hFF);      // R3: ignored while busy
    wait_tx();
    rd(1'b0, v); check(v, 8'h02, "R5 transmit done flag");
    repeat (100) @(negedge clk);
    check({7'd0, irq_tx}, 8'h01, "R5 flag stays set");
    wr(1'b0, 8'h00);

    // nine-bit transmit with ninth=1 then ninth=0, R4
    wr(1'b0, 8'h88);
    wr(1'b1, 8'h5A);
    wait_tx();
    wr(1'b0, 8'h80);
    wr(1'b1, 8'hC3);
    wait_tx();
    rd(1'b0, v); check(v, 8'h82, "R4 nine-bit frame done");
    wr(1'b0, 8'h80);

    // collision: software clear in the cycle the stop bit ends, R5
    wr(1'b1, 8'h81);
    forever begin
      @(negedge clk); #1;
      if (m_busy && q.size() == 0 && m_cnt == 1 && baud_tick) break;
    end
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h80;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    check({7'd0, irq_tx}, 8'h01, "R5 hardware set wins collision");
    wr(1'b0, 8'h00);
    repeat (2) @(negedge clk);
    check({7'd0, irq_tx}, 8'h00, "R5 later clear works");

    // eight-bit receive, filter off, R8 R13
    wr(1'b0, 8'h10);
    send(8'h96, 1'b0, 1'b0, 1'b1);
    expect_regs(8'h15, 8'h96, "R8 stop bit captured");
    check({7'd0, irq_rx}, 8'h01, "R13 receive request");
    // nine-bit receive, R7
    wr(1'b0, 8'h90);
    send(8'h3C, 1'b1, 1'b0, 1'b1);
    expect_regs(8'h91, 8'h3C, "R7 ninth bit 0");
    wr(1'b0, 8'h90);
    send(8'hC3, 1'b1, 1'b1, 1'b1);
    expect_regs(8'h95, 8'hC3, "R7 ninth bit 1");
    // address filter, R9
    wr(1'b0, 8'hB0);
    send(8'h11, 1'b1, 1'b0, 1'b1);
    expect_regs(8'hB0, 8'hC3, "R9 data frame dropped");
    send(8'h22, 1'b1, 1'b1, 1'b1);
    expect_regs(8'hB5, 8'h22, "R9 address frame accepted");
    // pending flag blocks, R11
    send(8'h44, 1'b1, 1'b1, 1'b1);
    expect_regs(8'hB5, 8'h22, "R11 frame dropped while flag set");
    // receive disabled, R6
    wr(1'b0, 8'h80);
    send(8'h55, 1'b1, 1'b1, 1'b1);
    expect_regs(8'h80, 8'h22, "R6 receive disabled");
    // short glitch rejected then real frame, R6
    wr(1'b0, 8'h90);
    rx_i = 1'b0;
    repeat (12) @(negedge clk);
    rx_i = 1'b1;
    repeat (800) @(negedge clk);
    expect_regs(8'h90, 8'h22, "R6 false start rejected");
    send(8'h66, 1'b1, 1'b1, 1'b1);
    expect_regs(8'h95, 8'h66, "R6 recovery after glitch");
    // eight-bit with filter, R10
    wr(1'b0, 8'h30);
    send(8'h77, 1'b0, 1'b0, 1'b0);
    expect_regs(8'h30, 8'h66, "R10 low stop dropped");
    send(8'hE1, 1'b0, 1'b0, 1'b1);
    expect_regs(8'h31, 8'hE1, "R10 accepted, ninth field kept");
    // R12 registered read latency: address switch shows after one edge
    @(negedge clk);
    reg_addr = 1'b0;
    @(negedge clk);
    reg_addr = 1'b1;
    #1;
    check(reg_rdata, 8'h31, "R12 read still shows previous select");
    @(negedge clk);
    check(reg_rdata, 8'hE1, "R12 read follows select");
    repeat (10) @(negedge clk);
    summary();
  end
endmodule